// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the control path of a NOR-style flash device. Bus write cycles carry a command byte on the data lines and an address. The controller decodes each command and keeps a persistent read mode. In that mode every later read returns one of four things: array data, identifier information, the status register, or the extended status register. The mode holds until another command is written.

Block erase takes two write cycles, a setup followed by a confirm. The address of the confirm cycle chooses the block. The erase engine is modelled as a busy counter that runs for a parameterised number of cycles. A test input can force the erase to fail. When it ends, the engine updates the status register and a failure flag for the erased block. The error bits in the status register stay set until a clear command is written, and that command is ignored while the suspend input is high.

A read cycle begins with a one-cycle `rd_start` pulse. On that edge the data for the current mode is latched into `rd_data` and held until the next pulse. This means a fresh read cycle is needed to see a status change.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the mode is array read, `rd_data` is zero, no error bit is set and the engine is idle. Array-mode reads return the parameter ARRAY_FILL.
- R2: Command bytes on `wr_data[7:0]` select the read mode: 0xFF array, 0x90 identifier, 0x70 status, 0xE8 extended status. Any byte outside the defined command set, including 0xD0 written with no setup before it, selects array mode. A mode stays in effect for all later reads until the next command.
- R3: In identifier mode, word address 0 returns MFR_CODE and word address 1 returns DEV_CODE. The word address is `rd_addr[ADDR_W-1:1]`, so `rd_addr[0]` has no effect.
- R4: In identifier mode, word offset 2 within a block returns the block's configuration byte. The block index is `rd_addr[ADDR_W-1 -: BLK_W]` and the offset is `rd_addr[ADDR_W-BLK_W-1:1]`. Bit 0 is the block's bit of LOCKED_MASK, bit 1 is 1 when the last erase of that block failed, and the other bits are 0.
- R5: Writing 0x20 and then 0xD0 starts an erase of the block `wr_addr[ADDR_W-1 -: BLK_W]` and switches to status mode. The engine stays busy for ERASE_CYC cycles after the confirm edge.
- R6: Status byte layout: bit 7 is ready, bit 5 is erase error, bit 4 is sequence error, and all other bits read 0. While the engine is busy a status read returns 0x00. When it is ready the full byte is returned.
- R7: If `force_fail_i` is high on the confirm cycle, the erase fails. A failed erase sets bit 5 and sets the block's failure flag. A successful erase clears that block's flag.
- R8: A setup followed by any byte other than 0xD0 sets bits 4 and 5, switches to status mode and starts no erase.
- R9: Bits 5 and 4 stay set until 0x50 is written. 0x50 has no effect while `suspend_i` is high, and it leaves the read mode unchanged.
- R10: `rd_data` is loaded only on a cycle with `rd_start` high and holds its value otherwise, even when the status changes.
- R11: Writing 0xE8 snapshots the extended status: bit 7 is the engine's ready state at that write, and the other bits are 0. The snapshot changes only when 0xE8 is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | ADDR_W | Write address; the upper BLK_W bits select the erase block |
| wr_data | input | DATA_W | Write data; bits 7:0 carry the command |
| rd_start | input | 1 | Start of a read cycle; latches read data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Latched read data |
| suspend_i | input | 1 | Suspend flag; blocks the clear command |
| force_fail_i | input | 1 | Test input; makes the confirmed erase fail |

## Verification
The bench uses ADDR_W=8, BLK_W=2 (four blocks, six offset bits), DATA_W=8, LOCKED_MASK=4'b0101 and ERASE_CYC=20. The short erase time lets the bench place a status read exactly on the last busy cycle and on the first ready cycle. With four blocks, it can show that the lock and failure bits differ between blocks. It can also show that a failure recorded for one block does not affect its neighbours.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      MODE_ARRAY  = 2'd0,
      MODE_IDENT  = 2'd1,
      MODE_STATUS = 2'd2,
      MODE_XSTAT  = 2'd3
   } rd_mode_e;

   localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
   localparam logic [7:0] CMD_READ_IDENT = 8'h90;
   localparam logic [7:0] CMD_READ_STAT  = 8'h70;
   localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;
   localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
   localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
   localparam logic [7:0] CMD_XSTAT      = 8'hE8;

   localparam int BIT_READY   = 7;
   localparam int BIT_ERASE_E = 5;
   localparam int BIT_SEQ_E   = 4;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
   import flash_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_cmd,
   input  logic       suspend_i,
   input  logic       busy,
   output rd_mode_e   mode,
   output logic       pending,
   output logic       erase_go,
   output logic       seq_err,
   output logic       clr_go,
   output logic       xsr_go
);

   rd_mode_e mode_d;
   logic     pend_d;

   always_comb begin
      erase_go = 1'b0;
      seq_err  = 1'b0;
      clr_go   = 1'b0;
      xsr_go   = 1'b0;
      mode_d   = mode;
      pend_d   = pending;
      if (wr_en) begin
         if (pending) begin
            pend_d = 1'b0;
            mode_d = MODE_STATUS;
            if (wr_cmd == CMD_CONFIRM) erase_go = !busy;
            else                       seq_err  = 1'b1;
         end else begin
            unique case (wr_cmd)
               CMD_READ_IDENT: mode_d = MODE_IDENT;
               CMD_READ_STAT:  mode_d = MODE_STATUS;
               CMD_CLEAR_STAT: clr_go = !suspend_i;
               CMD_ERASE_SET:  pend_d = 1'b1;
               CMD_XSTAT: begin
                  mode_d = MODE_XSTAT;
                  xsr_go = 1'b1;
               end
               default:        mode_d = MODE_ARRAY;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= MODE_ARRAY;
         pending <= 1'b0;
      end else begin
         mode    <= mode_d;
         pending <= pend_d;
      end
   end

endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine #(
   parameter int BLK_W     = 2,
   parameter int ERASE_CYC = 1000,
   localparam int NUM_BLK  = 1 << BLK_W,
   localparam int CNT_W    = $clog2(ERASE_CYC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [BLK_W-1:0]   go_blk,
   input  logic               force_fail_i,
   output logic               busy,
   output logic               done,
   output logic               done_fail,
   output logic [NUM_BLK-1:0] fail_flags
);

   logic [CNT_W-1:0] cnt;
   logic [BLK_W-1:0] cur_blk;
   logic             cur_fail;

   assign done      = busy && (cnt == '0);
   assign done_fail = done && cur_fail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         cur_blk  <= '0;
         cur_fail <= 1'b0;
      end else if (go) begin
         busy     <= 1'b1;
         cnt      <= CNT_W'(ERASE_CYC - 1);
         cur_blk  <= go_blk;
         cur_fail <= force_fail_i;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk_flag
      always_ff @(posedge clk) begin
         if (!rst_n)                            fail_flags[b] <= 1'b0;
         else if (done && cur_blk == BLK_W'(b)) fail_flags[b] <= cur_fail;
      end
   end

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
   import flash_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy,
   input  logic       done_fail,
   input  logic       seq_err,
   input  logic       clr_go,
   input  logic       xsr_go,
   output logic       err_erase,
   output logic       err_seq,
   output logic [7:0] sr_view,
   output logic [7:0] xsr_q
);

   always_comb begin
      sr_view = '0;
      if (!busy) begin
         sr_view[BIT_READY]   = 1'b1;
         sr_view[BIT_ERASE_E] = err_erase;
         sr_view[BIT_SEQ_E]   = err_seq;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_erase <= 1'b0;
         err_seq   <= 1'b0;
         xsr_q     <= '0;
      end else begin
         if (done_fail || seq_err) err_erase <= 1'b1;
         else if (clr_go)          err_erase <= 1'b0;
         if (seq_err)              err_seq   <= 1'b1;
         else if (clr_go)          err_seq   <= 1'b0;
         if (xsr_go)               xsr_q     <= {!busy, 7'b0};
      end
   end

endmodule

// File: rtl/flash_read_port.sv
module flash_read_port
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int BLK_W  = 2,
   parameter logic [DATA_W-1:0] MFR_CODE   = DATA_W'(8'h5A),
   parameter logic [DATA_W-1:0] DEV_CODE   = DATA_W'(8'hC3),
   parameter logic [DATA_W-1:0] ARRAY_FILL = '1,
   localparam int NUM_BLK = 1 << BLK_W,
   parameter logic [NUM_BLK-1:0] LOCKED_MASK = '0,
   localparam int OFF_W = ADDR_W - BLK_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_start,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  rd_mode_e           mode,
   input  logic [7:0]         sr_view,
   input  logic [7:0]         xsr_q,
   input  logic [NUM_BLK-1:0] fail_flags,
   output logic [DATA_W-1:0]  rd_data
);

   logic [BLK_W-1:0]  blk;
   logic [OFF_W-1:0]  off;
   logic [ADDR_W-2:0] waddr;
   logic [7:0]        cfg [NUM_BLK];
   logic [DATA_W-1:0] id_val;
   logic [DATA_W-1:0] rd_next;
   logic              unused_lsb;

   assign blk        = rd_addr[ADDR_W-1 -: BLK_W];
   assign off        = rd_addr[ADDR_W-BLK_W-1:1];
   assign waddr      = rd_addr[ADDR_W-1:1];
   assign unused_lsb = rd_addr[0];

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_cfg
      assign cfg[b] = {6'b0, fail_flags[b], LOCKED_MASK[b]};
   end

   always_comb begin
      if (waddr == '0)                 id_val = MFR_CODE;
      else if (waddr == (ADDR_W-1)'(1)) id_val = DEV_CODE;
      else if (off == OFF_W'(2))       id_val = DATA_W'(cfg[blk]);
      else                             id_val = '0;
   end

   always_comb begin
      unique case (mode)
         MODE_IDENT:  rd_next = id_val;
         MODE_STATUS: rd_next = DATA_W'(sr_view);
         MODE_XSTAT:  rd_next = DATA_W'(xsr_q);
         default:     rd_next = ARRAY_FILL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        rd_data <= '0;
      else if (rd_start) rd_data <= rd_next;
   end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int BLK_W     = 2,
   parameter int ERASE_CYC = 1000,
   parameter logic [DATA_W-1:0] MFR_CODE   = DATA_W'(8'h5A),
   parameter logic [DATA_W-1:0] DEV_CODE   = DATA_W'(8'hC3),
   parameter logic [DATA_W-1:0] ARRAY_FILL = '1,
   localparam int NUM_BLK = 1 << BLK_W,
   parameter logic [NUM_BLK-1:0] LOCKED_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_start,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              suspend_i,
   input  logic              force_fail_i
);

   if (BLK_W < 1 || ADDR_W - BLK_W < 3 || DATA_W < 8 || ERASE_CYC < 1) begin : g_param_bad
      initial $error("flash_cmd_ctrl: parameter set out of range");
   end

   rd_mode_e           mode_w;
   logic               pend_w, erase_go, seq_err, clr_go, xsr_go;
   logic               busy_w, done_w, done_fail_w;
   logic               err_erase_w, err_seq_w;
   logic [NUM_BLK-1:0] fail_flags;
   logic [7:0]         sr_view, xsr_q;
   logic               unused_bus_bits;

   assign unused_bus_bits = ^{wr_addr, wr_data, done_w};

   flash_cmd_decode u_decode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_data[7:0]),
      .suspend_i(suspend_i), .busy(busy_w), .mode(mode_w), .pending(pend_w),
      .erase_go(erase_go), .seq_err(seq_err), .clr_go(clr_go), .xsr_go(xsr_go)
   );

   flash_erase_engine #(.BLK_W(BLK_W), .ERASE_CYC(ERASE_CYC)) u_engine (
      .clk(clk), .rst_n(rst_n), .go(erase_go),
      .go_blk(wr_addr[ADDR_W-1 -: BLK_W]), .force_fail_i(force_fail_i),
      .busy(busy_w), .done(done_w), .done_fail(done_fail_w),
      .fail_flags(fail_flags)
   );

   flash_status_reg u_status (
      .clk(clk), .rst_n(rst_n), .busy(busy_w), .done_fail(done_fail_w),
      .seq_err(seq_err), .clr_go(clr_go), .xsr_go(xsr_go),
      .err_erase(err_erase_w), .err_seq(err_seq_w),
      .sr_view(sr_view), .xsr_q(xsr_q)
   );

   flash_read_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
      .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE),
      .ARRAY_FILL(ARRAY_FILL), .LOCKED_MASK(LOCKED_MASK)
   ) u_read (
      .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
      .mode(mode_w), .sr_view(sr_view), .xsr_q(xsr_q),
      .fail_flags(fail_flags), .rd_data(rd_data)
   );

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
   import flash_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        wr_cmd,
   input logic              suspend_i,
   input logic              rd_start,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy,
   input logic              pending,
   input rd_mode_e          mode,
   input logic              err_erase,
   input logic              err_seq
);

   // R6: a status read taken while busy returns all zeros
   assert_busy_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && busy && mode == MODE_STATUS) |=> (rd_data == '0));

   // R10: read data only moves on a read-cycle start
   assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_start |=> $stable(rd_data));

   // R8: broken erase sequence flags both errors and lands in status mode
   assert_seq_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pending && wr_cmd != CMD_CONFIRM) |=>
         (err_seq && err_erase && mode == MODE_STATUS));

   // R5: accepted confirm starts the engine
   assert_erase_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pending && wr_cmd == CMD_CONFIRM && !busy) |=>
         (busy && mode == MODE_STATUS));

   // R9: erase error stays set unless an effective clear is written
   assert_sticky_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_erase && !(wr_en && !pending && wr_cmd == CMD_CLEAR_STAT && !suspend_i))
         |=> err_erase);

   // R9: clear while suspended leaves sequence error untouched
   assert_clear_suspended_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_seq && wr_en && !pending && wr_cmd == CMD_CLEAR_STAT && suspend_i)
         |=> err_seq);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_data[7:0]),
   .suspend_i(suspend_i), .rd_start(rd_start), .rd_data(rd_data),
   .busy(busy_w), .pending(pend_w), .mode(mode_w),
   .err_erase(err_erase_w), .err_seq(err_seq_w)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;
   localparam int BLK_W  = 2;
   localparam int CYC    = 20;
   localparam logic [7:0] MFR  = 8'h5A;
   localparam logic [7:0] DEV  = 8'hC3;
   localparam logic [7:0] FILL = 8'hFF;
   localparam logic [3:0] LMASK = 4'b0101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_start = 1'b0, suspend_i = 1'b0, force_fail_i = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   flash_cmd_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .ERASE_CYC(CYC),
      .MFR_CODE(MFR), .DEV_CODE(DEV), .ARRAY_FILL(FILL), .LOCKED_MASK(LMASK)
   ) u_flash_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_start(rd_start), .rd_addr(rd_addr),
      .rd_data(rd_data), .suspend_i(suspend_i), .force_fail_i(force_fail_i)
   );

   // bench model: 0 array, 1 ident, 2 status, 3 xstat
   int         m_mode = 0;
   bit         m_e5 = 0, m_e4 = 0;
   bit [3:0]   m_fail = '0;
   logic [7:0] m_xsr = 8'h00;

   function automatic logic [7:0] exp_id(logic [7:0] a);
      if (a[7:1] == 0) return MFR;
      if (a[7:1] == 1) return DEV;
      if (a[5:1] == 2) return {6'b0, m_fail[a[7:6]], LMASK[a[7:6]]};
      return 8'h00;
   endfunction

   function automatic logic [7:0] exp_read(logic [7:0] a);
      case (m_mode)
         1:       return exp_id(a);
         2:       return {1'b1, 1'b0, m_e5, m_e4, 4'b0};
         3:       return m_xsr;
         default: return FILL;
      endcase
   endfunction

   task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%02h expected=%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] cmd, input logic [7:0] addr);
      wr_en = 1'b1; wr_data = cmd; wr_addr = addr;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] addr);
      rd_start = 1'b1; rd_addr = addr;
      @(negedge clk);
      rd_start = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got=hang expected=finish");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check(rd_data, 8'h00, "R1 reset rd_data");
      rd(8'h10); check(rd_data, FILL, "R1 array fill");
      wr(8'h70, 0); rd(0); check(rd_data, 8'h80, "R1 idle status");

      // R3/R4 identifier reads
      wr(8'h90, 0);
      rd(8'h00); check(rd_data, MFR, "R3 word0");
      rd(8'h01); check(rd_data, MFR, "R3 lsb ignored");
      rd(8'h02); check(rd_data, DEV, "R3 word1");
      rd(8'h03); check(rd_data, DEV, "R3 word1 lsb");
      rd(8'h04); check(rd_data, 8'h01, "R4 blk0 locked");
      rd(8'h44); check(rd_data, 8'h00, "R4 blk1 unlocked");
      rd(8'h85); check(rd_data, 8'h01, "R4 blk2 locked");
      rd(8'h46); check(rd_data, 8'h00, "R4 offset3 zero");
      rd(8'h00); check(rd_data, MFR, "R2 mode persists");

      // R5/R6 passing erase on block 3, exact busy window
      wr(8'h20, 0); wr(8'hD0, 8'hC0);
      rd(0); check(rd_data, 8'h00, "R6 busy read");
      idle(CYC - 2);
      rd(0); check(rd_data, 8'h00, "R5 last busy cycle");
      rd(0); check(rd_data, 8'h80, "R5 ready after window");
      wr(8'h90, 0); rd(8'hC4); check(rd_data, 8'h00, "R7 blk3 pass");

      // R7 forced failure on block 1
      force_fail_i = 1'b1;
      wr(8'h20, 0); wr(8'hD0, 8'h40);
      force_fail_i = 1'b0;
      idle(CYC + 2);
      rd(0); check(rd_data, 8'hA0, "R7 status after fail");
      wr(8'h90, 0);
      rd(8'h44); check(rd_data, 8'h02, "R7 blk1 fail flag");
      rd(8'h04); check(rd_data, 8'h01, "R7 blk0 untouched");

      // R10 hold across status change, R9 stickiness, R7 flag cleared by pass
      wr(8'h70, 0); rd(0); check(rd_data, 8'hA0, "R10 status latched");
      wr(8'h20, 0); wr(8'hD0, 8'h40);
      rd(0); check(rd_data, 8'h00, "R6 busy masks errors");
      idle(CYC + 3);
      check(rd_data, 8'h00, "R10 held without new read");
      rd(0); check(rd_data, 8'hA0, "R9 error sticky");
      wr(8'h90, 0); rd(8'h44); check(rd_data, 8'h00, "R7 flag cleared");

      // R9 clear gated by suspend
      wr(8'h70, 0);
      suspend_i = 1'b1; wr(8'h50, 0); suspend_i = 1'b0;
      rd(0); check(rd_data, 8'hA0, "R9 clear ignored suspended");
      wr(8'h50, 0);
      rd(0); check(rd_data, 8'h80, "R9 clear keeps mode");

      // R8 sequence error
      wr(8'h20, 0); wr(8'hFF, 8'h40);
      rd(0); check(rd_data, 8'hB0, "R8 seq error no erase");
      wr(8'h50, 0); rd(0); check(rd_data, 8'h80, "R9 seq cleared");

      // R11 extended status snapshot
      wr(8'hE8, 0); rd(0); check(rd_data, 8'h80, "R11 xsr ready");
      wr(8'h20, 0); wr(8'hD0, 8'h00);
      wr(8'hE8, 0); rd(0); check(rd_data, 8'h00, "R11 xsr busy");
      idle(CYC + 3);
      rd(0); check(rd_data, 8'h00, "R11 no refresh");
      wr(8'hE8, 0); rd(0); check(rd_data, 8'h80, "R11 reissued");

      // R2 unknown code and lone confirm
      wr(8'h90, 0); wr(8'h33, 0); rd(8'h02); check(rd_data, FILL, "R2 unknown to array");
      wr(8'h90, 0); wr(8'hD0, 0); rd(8'h02); check(rd_data, FILL, "R2 lone confirm");

      // random phase
      m_mode = 0; m_e5 = 0; m_e4 = 0; m_fail = '0; m_xsr = 8'h80;
      void'($urandom(32'h1F2E3D4C));
      for (int i = 0; i < 400; i++) begin
         int sel = $urandom_range(0, 9);
         logic [7:0] a = 8'($urandom);
         logic [7:0] c;
         case (sel)
            0: c = 8'hFF; 1: c = 8'h90; 2: c = 8'h70; 3: c = 8'hE8;
            4: c = 8'h50;
            5: begin
               c = 8'($urandom);
               if (c == 8'h20 || c == 8'h50 || c == 8'h70 || c == 8'h90 || c == 8'hE8)
                  c = 8'h3C;
            end
            default: c = 8'h00;
         endcase
         if (sel == 6) begin
            wr(8'h20, 0);
            c = 8'($urandom);
            if (c == 8'hD0) c = 8'h11;
            wr(c, a);
            m_e5 = 1; m_e4 = 1; m_mode = 2;
         end else if (sel <= 5) begin
            suspend_i = ($urandom_range(0, 3) == 0);
            wr(c, a);
            case (c)
               8'h90: m_mode = 1;
               8'h70: m_mode = 2;
               8'hE8: m_mode = 3;
               8'h50: if (!suspend_i) begin m_e5 = 0; m_e4 = 0; end
               default: m_mode = 0;
            endcase
            suspend_i = 1'b0;
         end
         rd(a);
         check(rd_data, exp_read(a), "R2 random read");
      end
      finish_run();
   end

endmodule